// File: doc/BRIEF.md
# Windowed Register File with Overlapping Call Frames

This block is the register file of a small RISC core. Calls and returns do not copy registers. Instead the block renames architectural register numbers onto a larger physical store. A current window pointer selects one of several register windows, which are arranged as a ring. Each window has three areas: incoming parameters, private locals and outgoing temporaries. A window's outgoing temporaries are the same physical registers as the next window's incoming parameters. A caller therefore leaves arguments in its temporaries, and after the call the callee finds them in its parameter area. A bank of globals sits beside the windows, and every window sees the same globals.

Architectural numbers 0-7 select the globals, 8-15 the parameters, 16-23 the locals and 24-31 the temporaries. The core reads through two combinational ports and writes through one synchronous port. A call strobe moves the window pointer forward and a return strobe moves it back. A saved window pointer marks the window that was most recently spilled to memory, and no call or return may land on it.

A call that would land on that window raises an overflow trap. A return that would land on it raises an underflow trap. A trap handler then uses a separate handler port to read or write any physical window register directly. It steps the saved pointer by one for each window it moves, and acknowledges the trap so that the core can retry the call or return.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the current window pointer is 0, the saved window pointer is NWIN-1 (7), both traps are low and every register reads zero.
- R2: Architectural registers 0-7 map to one global bank shared by all windows; a value written there reads back unchanged after any number of calls or returns.
- R3: With current window c, registers 8-15 are the parameters of window c, 16-23 its locals, and 24-31 the parameters of window (c+1) mod NWIN; locals of one window are not visible from another.
- R4: Both core read ports are combinational; a write on the write port takes effect at the clock edge, so a read of the same register in the write cycle returns the old value.
- R5: A call strobe with no trap pending advances the current pointer by one modulo NWIN; a return strobe moves it back by one.
- R6: A call whose target window (c+1) mod NWIN equals the saved pointer leaves the current pointer unchanged and sets the overflow trap output from the next cycle.
- R7: A return whose target window (c-1) mod NWIN equals the saved pointer leaves the current pointer unchanged and sets the underflow trap output from the next cycle.
- R8: While either trap is set, call and return strobes are ignored; a trap acknowledge clears both traps at the next edge.
- R9: The handler port addresses window hs_win at offset hs_off (offsets 0-7 are the parameters, 8-15 the locals), reads combinationally and writes at the edge; if the handler and the core write the same physical register in one cycle, the handler's value is kept.
- R10: A spill-step strobe advances the saved pointer by one and a fill-step strobe moves it back by one; both together leave it unchanged.
- R11: Call and return strobes asserted in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs1_idx | input | 5 | Architectural number, read port 1 |
| rs1_data | output | 32 | Read data, port 1 |
| rs2_idx | input | 5 | Architectural number, read port 2 |
| rs2_data | output | 32 | Read data, port 2 |
| wr_en | input | 1 | Core write enable |
| wr_idx | input | 5 | Architectural number written |
| wr_data | input | 32 | Core write data |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Return strobe |
| cwp | output | 3 | Current window pointer |
| swp | output | 3 | Saved window pointer |
| ovf_trap | output | 1 | Overflow trap pending |
| unf_trap | output | 1 | Underflow trap pending |
| trap_ack | input | 1 | Handler done, clears pending trap |
| hs_win | input | 3 | Handler port window index |
| hs_off | input | 4 | Handler port offset in window |
| hs_we | input | 1 | Handler port write enable |
| hs_wdata | input | 32 | Handler port write data |
| hs_rdata | output | 32 | Handler port read data |
| spill_adv | input | 1 | Spill completed, step saved pointer forward |
| fill_adv | input | 1 | Fill completed, step saved pointer back |

## Verification
The bench builds the block with its default values: eight windows, eight registers per area and 32-bit data. With eight windows, six nested calls from reset reach the overflow point. After one spill step a seventh call succeeds and puts the current window on the last window. That window's temporaries then wrap onto the parameters of window 0, so the ring boundary is exercised through the handler port. Seven returns afterwards carry the pointer back to window 0, and one more return reaches the underflow point.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

   // area selected by the two top bits of an architectural number
   typedef enum logic [1:0] {
      AR_GLOBAL = 2'd0,
      AR_PARAM  = 2'd1,
      AR_LOCAL  = 2'd2,
      AR_TEMP   = 2'd3
   } area_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rwf_map.sv
module rwf_map
   import rwf_pkg::*;
#(
   parameter int NWIN  = 8,
   parameter int AREA  = 8,
   localparam int WPW  = $clog2(NWIN),
   localparam int LW   = $clog2(AREA),
   localparam int AW   = LW + 2,
   localparam int NPHY = AREA + NWIN * 2 * AREA,
   localparam int PIW  = $clog2(NPHY)
) (
   input  logic [WPW-1:0] win,
   input  logic [AW-1:0]  arch,
   output logic [PIW-1:0] phys
);

   area_e          area;
   logic [LW-1:0]  off;
   logic [WPW-1:0] nxt;
   logic [PIW-1:0] base_cur;
   logic [PIW-1:0] base_nxt;

   assign area     = area_e'(arch[AW-1 -: 2]);
   assign off      = arch[LW-1:0];
   assign nxt      = win + WPW'(1);
   assign base_cur = PIW'(AREA) + PIW'(win) * PIW'(2 * AREA);
   assign base_nxt = PIW'(AREA) + PIW'(nxt) * PIW'(2 * AREA);

   always_comb begin
      unique case (area)
         AR_GLOBAL: phys = PIW'(off);
         AR_PARAM:  phys = base_cur + PIW'(off);
         AR_LOCAL:  phys = base_cur + PIW'(AREA) + PIW'(off);
         default:   phys = base_nxt + PIW'(off);
      endcase
   end

endmodule

// File: rtl/rwf_ptr.sv
module rwf_ptr #(
   parameter int NWIN = 8,
   localparam int WPW = $clog2(NWIN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           call_req,
   input  logic           ret_req,
   input  logic           trap_ack,
   input  logic           spill_adv,
   input  logic           fill_adv,
   output logic [WPW-1:0] cwp,
   output logic [WPW-1:0] swp,
   output logic           ovf_trap,
   output logic           unf_trap
);

   logic           pending;
   logic [WPW-1:0] cwp_up;
   logic [WPW-1:0] cwp_dn;

   assign pending = ovf_trap | unf_trap;
   assign cwp_up  = cwp + WPW'(1);
   assign cwp_dn  = cwp - WPW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp      <= '0;
         ovf_trap <= 1'b0;
         unf_trap <= 1'b0;
      end else if (pending) begin
         if (trap_ack) begin
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
         end
      end else if (call_req && !ret_req) begin
         if (cwp_up == swp) ovf_trap <= 1'b1;
         else               cwp      <= cwp_up;
      end else if (ret_req && !call_req) begin
         if (cwp_dn == swp) unf_trap <= 1'b1;
         else               cwp      <= cwp_dn;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      swp <= WPW'(NWIN - 1);
      else if (spill_adv && !fill_adv) swp <= swp + WPW'(1);
      else if (fill_adv && !spill_adv) swp <= swp - WPW'(1);
   end

endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
   parameter int DW        = 32,
   parameter int NPHY      = 136,
   parameter bit RST_CLEAR = 1'b1,
   localparam int PIW      = $clog2(NPHY)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           a_en,
   input  logic [PIW-1:0] a_idx,
   input  logic [DW-1:0]  a_data,
   input  logic           b_en,
   input  logic [PIW-1:0] b_idx,
   input  logic [DW-1:0]  b_data,
   input  logic [PIW-1:0] rd_idx [3],
   output logic [DW-1:0]  rd_data [3]
);

   logic [DW-1:0] mem [NPHY];

   // later write wins: port b (handler) has priority on a shared index
   if (RST_CLEAR) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NPHY; i++) mem[i] <= '0;
         end else begin
            if (a_en) mem[a_idx] <= a_data;
            if (b_en) mem[b_idx] <= b_data;
         end
      end
   end else begin : g_noclr
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (a_en) mem[a_idx] <= a_data;
         if (b_en) mem[b_idx] <= b_data;
      end
   end

   for (genvar k = 0; k < 3; k++) begin : g_rd
      assign rd_data[k] = mem[rd_idx[k]];
   end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
   import rwf_pkg::*;
#(
   parameter int NWIN      = 8,
   parameter int AREA      = 8,
   parameter int DW        = 32,
   parameter bit RST_CLEAR = 1'b1,
   localparam int WPW      = $clog2(NWIN),
   localparam int LW       = $clog2(AREA),
   localparam int AW       = LW + 2,
   localparam int OW       = LW + 1,
   localparam int NPHY     = AREA + NWIN * 2 * AREA,
   localparam int PIW      = $clog2(NPHY)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  rs1_idx,
   output logic [DW-1:0]  rs1_data,
   input  logic [AW-1:0]  rs2_idx,
   output logic [DW-1:0]  rs2_data,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_idx,
   input  logic [DW-1:0]  wr_data,
   input  logic           call_req,
   input  logic           ret_req,
   output logic [WPW-1:0] cwp,
   output logic [WPW-1:0] swp,
   output logic           ovf_trap,
   output logic           unf_trap,
   input  logic           trap_ack,
   input  logic [WPW-1:0] hs_win,
   input  logic [OW-1:0]  hs_off,
   input  logic           hs_we,
   input  logic [DW-1:0]  hs_wdata,
   output logic [DW-1:0]  hs_rdata,
   input  logic           spill_adv,
   input  logic           fill_adv
);

   if (!is_pow2(NWIN) || NWIN < 3) begin : g_bad_nwin
      $error("NWIN must be a power of two, at least 4");
   end
   if (!is_pow2(AREA)) begin : g_bad_area
      $error("AREA must be a power of two");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [AW-1:0]  arch_sel [3];
   logic [PIW-1:0] phys_sel [3];
   logic [PIW-1:0] rd_idx   [3];
   logic [DW-1:0]  rd_data  [3];
   logic [PIW-1:0] hs_phys;

   assign arch_sel[0] = rs1_idx;
   assign arch_sel[1] = rs2_idx;
   assign arch_sel[2] = wr_idx;

   for (genvar p = 0; p < 3; p++) begin : g_map
      rwf_map #(.NWIN(NWIN), .AREA(AREA)) u_map (
         .win  (cwp),
         .arch (arch_sel[p]),
         .phys (phys_sel[p])
      );
   end

   assign hs_phys = PIW'(AREA) + PIW'(hs_win) * PIW'(2 * AREA) + PIW'(hs_off);

   rwf_ptr #(.NWIN(NWIN)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .call_req  (call_req),
      .ret_req   (ret_req),
      .trap_ack  (trap_ack),
      .spill_adv (spill_adv),
      .fill_adv  (fill_adv),
      .cwp       (cwp),
      .swp       (swp),
      .ovf_trap  (ovf_trap),
      .unf_trap  (unf_trap)
   );

   assign rd_idx[0] = phys_sel[0];
   assign rd_idx[1] = phys_sel[1];
   assign rd_idx[2] = hs_phys;

   rwf_store #(.DW(DW), .NPHY(NPHY), .RST_CLEAR(RST_CLEAR)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_en    (wr_en),
      .a_idx   (phys_sel[2]),
      .a_data  (wr_data),
      .b_en    (hs_we),
      .b_idx   (hs_phys),
      .b_data  (hs_wdata),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   assign rs1_data = rd_data[0];
   assign rs2_data = rd_data[1];
   assign hs_rdata = rd_data[2];

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
   parameter int NWIN = 8,
   localparam int WPW = $clog2(NWIN)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           call_req,
   input logic           ret_req,
   input logic           trap_ack,
   input logic [WPW-1:0] cwp,
   input logic [WPW-1:0] swp,
   input logic           ovf_trap,
   input logic           unf_trap
);

   logic pend;
   logic do_call;
   logic do_ret;
   assign pend    = ovf_trap | unf_trap;
   assign do_call = call_req && !ret_req && !pend;
   assign do_ret  = ret_req && !call_req && !pend;

   // R5
   call_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_call && WPW'(cwp + WPW'(1)) != swp) |=> cwp == WPW'($past(cwp) + WPW'(1)));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_call && WPW'(cwp + WPW'(1)) == swp) |=> (ovf_trap && $stable(cwp)));

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_ret && WPW'(cwp - WPW'(1)) == swp) |=> (unf_trap && $stable(cwp)));

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> $stable(cwp));

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && trap_ack) |=> (!ovf_trap && !unf_trap));

   // R11
   both_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && ret_req) |=> $stable(cwp));

   // R6
   trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_trap && unf_trap));

endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN)) u_chk (.*);

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rs1_idx = '0, rs2_idx = '0, wr_idx = '0;
   logic [31:0] rs1_data, rs2_data, wr_data = '0;
   logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0, trap_ack = 1'b0;
   logic [2:0]  cwp, swp, hs_win = '0;
   logic [3:0]  hs_off = '0;
   logic        hs_we = 1'b0, spill_adv = 1'b0, fill_adv = 1'b0;
   logic [31:0] hs_wdata = '0, hs_rdata;
   logic        ovf_trap, unf_trap;

   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   rwin_regfile u_dut (
      .clk(clk), .rst_n(rst_n),
      .rs1_idx(rs1_idx), .rs1_data(rs1_data),
      .rs2_idx(rs2_idx), .rs2_data(rs2_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .call_req(call_req), .ret_req(ret_req),
      .cwp(cwp), .swp(swp), .ovf_trap(ovf_trap), .unf_trap(unf_trap),
      .trap_ack(trap_ack),
      .hs_win(hs_win), .hs_off(hs_off), .hs_we(hs_we),
      .hs_wdata(hs_wdata), .hs_rdata(hs_rdata),
      .spill_adv(spill_adv), .fill_adv(fill_adv)
   );

   // kind: 0 write, 1 read-compare, 2 call (expect cwp), 3 return (expect cwp)
   localparam logic [38:0] VEC [16] = '{
      {2'd0, 5'd3,  32'hA1A1_0003},
      {2'd0, 5'd9,  32'hB1B1_0009},
      {2'd0, 5'd17, 32'hC1C1_0011},
      {2'd0, 5'd25, 32'hD1D1_0019},
      {2'd1, 5'd25, 32'hD1D1_0019},
      {2'd2, 5'd0,  32'd1},
      {2'd1, 5'd9,  32'hD1D1_0019},
      {2'd1, 5'd17, 32'h0},
      {2'd1, 5'd3,  32'hA1A1_0003},
      {2'd0, 5'd17, 32'hE1E1_0011},
      {2'd0, 5'd3,  32'hF1F1_0003},
      {2'd3, 5'd0,  32'd0},
      {2'd1, 5'd17, 32'hC1C1_0011},
      {2'd1, 5'd3,  32'hF1F1_0003},
      {2'd1, 5'd25, 32'hD1D1_0019},
      {2'd1, 5'd9,  32'hB1B1_0009}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] r);
      rs1_idx = r;
      rs2_idx = r;
      #1;
   endtask

   task automatic pulse_call();
      call_req = 1'b1; tick(); call_req = 1'b0;
   endtask

   task automatic pulse_ret();
      ret_req = 1'b1; tick(); ret_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 reset values, checked while held in reset
      rd(5'd3);
      chk("R1 cwp", 32'(cwp), 32'd0);
      chk("R1 swp", 32'(swp), 32'd7);
      chk("R1 traps", {30'd0, ovf_trap, unf_trap}, 32'd0);
      chk("R1 read", rs1_data, 32'd0);
      rst_n = 1'b1;
      tick();

      // vector table: R2, R3, R5
      for (int i = 0; i < 16; i++) begin
         logic [1:0]  kind;
         logic [4:0]  idx;
         logic [31:0] val;
         {kind, idx, val} = VEC[i];
         case (kind)
            2'd0: begin
               wr_en = 1'b1; wr_idx = idx; wr_data = val;
               tick();
               wr_en = 1'b0;
            end
            2'd1: begin
               rd(idx);
               chk($sformatf("R2/R3 vec %0d port1", i), rs1_data, val);
               chk($sformatf("R2/R3 vec %0d port2", i), rs2_data, val);
            end
            2'd2: begin
               pulse_call();
               chk($sformatf("R5 call vec %0d", i), 32'(cwp), val);
            end
            default: begin
               pulse_ret();
               chk($sformatf("R5 return vec %0d", i), 32'(cwp), val);
            end
         endcase
      end

      // R4 write-cycle read returns old value
      wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'h55;
      rd(5'd20);
      chk("R4 same cycle old", rs1_data, 32'h0);
      tick();
      wr_en = 1'b0;
      chk("R4 after edge", rs1_data, 32'h55);

      // R9 handler write wins on shared physical register (win0 param1 = r9)
      wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h1111;
      hs_we = 1'b1; hs_win = 3'd0; hs_off = 4'd1; hs_wdata = 32'h2222;
      tick();
      wr_en = 1'b0; hs_we = 1'b0;
      rd(5'd9);
      chk("R9 priority", rs1_data, 32'h2222);

      // R6 overflow after six calls
      for (int i = 0; i < 6; i++) pulse_call();
      chk("R5 six calls", 32'(cwp), 32'd6);
      pulse_call();
      chk("R6 ovf set", 32'(ovf_trap), 32'd1);
      chk("R6 cwp held", 32'(cwp), 32'd6);
      // R8 strobes ignored while pending
      pulse_call();
      chk("R8 call ignored", 32'(cwp), 32'd6);
      pulse_ret();
      chk("R8 ret ignored", 32'(cwp), 32'd6);
      trap_ack = 1'b1; tick(); trap_ack = 1'b0;
      chk("R8 ack clears", 32'(ovf_trap), 32'd0);

      // R9 handler reads of oldest window
      hs_win = 3'd0; hs_off = 4'd1; #1;
      chk("R9 spill read param", hs_rdata, 32'h2222);
      hs_off = 4'd9; #1;
      chk("R9 spill read local", hs_rdata, 32'hC1C1_0011);
      // R10 spill step
      spill_adv = 1'b1; tick(); spill_adv = 1'b0;
      chk("R10 spill step", 32'(swp), 32'd0);
      pulse_call();
      chk("R5 call to last", 32'(cwp), 32'd7);
      // R3 temporaries of window 7 wrap onto window 0 parameters
      wr_en = 1'b1; wr_idx = 5'd26; wr_data = 32'h3333;
      tick();
      wr_en = 1'b0;
      hs_win = 3'd0; hs_off = 4'd2; #1;
      chk("R3 wrap overlap", hs_rdata, 32'h3333);
      pulse_call();
      chk("R6 ovf at wrap", 32'(ovf_trap), 32'd1);
      trap_ack = 1'b1; tick(); trap_ack = 1'b0;

      // R11 call and return together
      call_req = 1'b1; ret_req = 1'b1; tick();
      call_req = 1'b0; ret_req = 1'b0;
      chk("R11 both ignored", 32'(cwp), 32'd7);
      // R10 both steps together
      spill_adv = 1'b1; fill_adv = 1'b1; tick();
      spill_adv = 1'b0; fill_adv = 1'b0;
      chk("R10 both steps", 32'(swp), 32'd0);

      // R9 fill write then R10 fill step
      hs_we = 1'b1; hs_win = 3'd0; hs_off = 4'd9; hs_wdata = 32'h77;
      tick();
      hs_we = 1'b0;
      fill_adv = 1'b1; tick(); fill_adv = 1'b0;
      chk("R10 fill step", 32'(swp), 32'd7);
      for (int i = 0; i < 7; i++) pulse_ret();
      chk("R5 seven returns", 32'(cwp), 32'd0);
      rd(5'd17);
      chk("R9 filled local", rs1_data, 32'h77);
      rd(5'd10);
      chk("R3 param via temp", rs1_data, 32'h3333);
      rd(5'd3);
      chk("R2 global kept", rs2_data, 32'hF1F1_0003);

      // R7 underflow
      pulse_ret();
      chk("R7 unf set", 32'(unf_trap), 32'd1);
      chk("R7 cwp held", 32'(cwp), 32'd0);
      trap_ack = 1'b1; tick(); trap_ack = 1'b0;
      chk("R8 unf cleared", 32'(unf_trap), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule